// File: doc/BRIEF.md
# Isochronous Bus Cycle Timer

This block keeps the 32-bit bus time of a serial-bus link layer. A clock-enable pulse at the nominal 24.576 MHz rate advances a chain of three counters. The low offset counter counts ticks within one 125 us cycle. The middle counter counts cycles within one second. The top counter counts seconds. All three wrap at irregular points, and each wrap carries into the next counter. Software reads and writes the timer and its controls through a plain register port. A write always wins over counting in the same clock.

The node takes one of two roles. As cycle master it free-runs on its own offset wrap. Otherwise it is resynchronized by received cycle-start events, each of which carries a full 32-bit time value. There is also a cycle-source mode, in which an external 8 kHz strobe marks each cycle boundary instead of the internal offset wrap.

The block tracks two status bits: cycle pending, and cycle lost (two boundaries passed with no cycle start received). It raises sticky event flags for a seconds advance, a cycle boundary and a lost cycle. A mask gates these flags onto one interrupt line.

The received cycle-start port is a valid-only event stream. It cannot be back-pressured and has no ready signal. A pulse on `cs_valid` is accepted in the clock where it is high, or ignored under the rules below. The tick, strobe and end-of-cycle inputs are plain single-clock pulses.

Top module: `cyc_timer`

## Requirements
- R1: After reset, the timer, the control bits, the flags, the mask, `cyc_pending`, `cyc_lost` and `irq` are all 0.
- R2: The timer layout is seconds in bits [31:25], cycle count in [24:12] and offset in [11:0]. While enabled and not in source mode, each `tick` advances the offset by one. From OFF_WRAP-1 it wraps to 0 and adds one to the cycle count.
- R3: The cycle count wraps from CYC_WRAP-1 to 0 and adds one to seconds. Seconds wraps from SEC_WRAP-1 to 0. Every seconds advance by counting sets flag bit 0.
- R4: With the enable bit (control bit 0) clear, the timer does not change except through a register write, and received cycle starts are ignored.
- R5: With the source bit (control bit 2) set, a `src_strobe` forces the offset to 0 and advances the cycle count, carrying as in R3. A `tick` without a strobe advances the offset but holds it at OFF_WRAP-1, and it never carries.
- R6: A write to address 0x14 loads all 32 timer bits in the next cycle. It takes priority over a tick, a strobe or a cycle start in the same clock.
- R7: When enabled and the master bit (control bit 1) is clear, `cs_valid` loads the timer with `cs_time`. With the master bit set, `cs_valid` is ignored.
- R8: Each cycle boundary reached by counting (an offset wrap, or a strobe in source mode) sets `cyc_pending` and flag bit 1. `cyc_done` clears `cyc_pending`. If a boundary and `cyc_done` arrive in the same clock, the set wins.
- R9: When not master, a boundary that follows an earlier boundary with no accepted cycle start in between sets `cyc_lost` and flag bit 2. An accepted cycle start clears `cyc_lost` and the boundary history. In master mode `cyc_lost` is held at 0.
- R10: Flags are sticky. Writing 1s to address 0x04 clears the matching bits, and a set in the same clock wins over the clear. Address 0x08 holds a 3-bit mask. `irq` is the OR of flags ANDed with mask.
- R11: Reads are combinational. Address 0x00 returns control {source, master, enable} in bits [2:0]. Address 0x04 returns the flags, 0x08 the mask, and 0x0C the status {lost, pending} in bits [1:0]. Address 0x14 returns the timer. Any other address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | 24.576 MHz clock-enable pulse for the offset counter |
| src_strobe | input | 1 | External 8 kHz cycle boundary strobe (source mode) |
| cs_valid | input | 1 | Received cycle-start event, valid-only |
| cs_time | input | 32 | Time value carried by the received cycle start |
| cyc_done | input | 1 | End-of-cycle pulse (subaction gap after cycle start) |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| cycle_time | output | 32 | Current timer value |
| cyc_pending | output | 1 | Cycle pending status |
| cyc_lost | output | 1 | Cycle lost status |
| irq | output | 1 | Masked OR of the event flags |

## Verification
A wrong carry or a wrong wrap point shows up on `cycle_time` in the first clock after the offending tick or strobe. The bench therefore compares the full timer after every step across complete seconds wraps of a reduced configuration. A wrong pending or lost state shows up on `cyc_pending`, `cyc_lost` and `irq` in the clock after the boundary or cycle start that should have changed it. The sticky flags expose any missed event through register reads long after it happened, until software clears them.

// File: rtl/ct_pkg.sv
package ct_pkg;
  localparam int TIME_W = 32;
  localparam int OFF_W  = 12;
  localparam int CYC_W  = 13;
  localparam int SEC_W  = 7;
  localparam int NFLAG  = 3;
  localparam int ADDR_W = 8;

  localparam int FB_SEC  = 0;
  localparam int FB_PEND = 1;
  localparam int FB_LOST = 2;

  localparam logic [ADDR_W-1:0] A_CTRL = 8'h00;
  localparam logic [ADDR_W-1:0] A_FLAG = 8'h04;
  localparam logic [ADDR_W-1:0] A_MASK = 8'h08;
  localparam logic [ADDR_W-1:0] A_STAT = 8'h0C;
  localparam logic [ADDR_W-1:0] A_TIME = 8'h14;

  typedef struct packed {
    logic src;
    logic master;
    logic en;
  } ctrl_t;

  typedef struct packed {
    logic [SEC_W-1:0] sec;
    logic [CYC_W-1:0] cyc;
    logic [OFF_W-1:0] off;
  } ctime_t;
endpackage

// File: rtl/ct_regs.sv
module ct_regs
  import ct_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [NFLAG-1:0]  wdata_lo,
  input  logic [NFLAG-1:0]  flags,
  input  logic              pending,
  input  logic              lost,
  input  ctime_t            time_q,
  output ctrl_t             ctrl,
  output logic [NFLAG-1:0]  mask,
  output logic [NFLAG-1:0]  flag_clr,
  output logic              time_wr,
  output logic [TIME_W-1:0] rdata
);
  logic wr_ctrl, wr_mask, wr_flag;

  assign wr_ctrl = reg_wr && (reg_addr == A_CTRL);
  assign wr_mask = reg_wr && (reg_addr == A_MASK);
  assign wr_flag = reg_wr && (reg_addr == A_FLAG);
  assign time_wr = reg_wr && (reg_addr == A_TIME);
  assign flag_clr = wr_flag ? wdata_lo : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '0;
      mask <= '0;
    end else begin
      if (wr_ctrl) ctrl <= ctrl_t'(wdata_lo);
      if (wr_mask) mask <= wdata_lo;
    end
  end

  always_comb begin
    rdata = '0;
    case (reg_addr)
      A_CTRL:  rdata[NFLAG-1:0] = ctrl;
      A_FLAG:  rdata[NFLAG-1:0] = flags;
      A_MASK:  rdata[NFLAG-1:0] = mask;
      A_STAT:  rdata[1:0] = {lost, pending};
      A_TIME:  rdata = time_q;
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/ct_counter.sv
module ct_counter
  import ct_pkg::*;
#(
  parameter int OFF_WRAP = 3072,
  parameter int CYC_WRAP = 8000,
  parameter int SEC_WRAP = 128
)(
  input  logic              clk,
  input  logic              rst_n,
  input  ctrl_t             ctrl,
  input  logic              tick,
  input  logic              src_strobe,
  input  logic              cs_valid,
  input  logic [TIME_W-1:0] cs_time,
  input  logic              time_wr,
  input  logic [TIME_W-1:0] time_wdata,
  output ctime_t            time_q,
  output logic              roll,
  output logic              sec_step,
  output logic              cs_load
);
  localparam logic [OFF_W-1:0] OFF_MAX = OFF_W'(OFF_WRAP - 1);
  localparam logic [CYC_W-1:0] CYC_MAX = CYC_W'(CYC_WRAP - 1);
  localparam logic [SEC_W-1:0] SEC_MAX = SEC_W'(SEC_WRAP - 1);

  ctime_t nxt;
  logic   adv_cyc;

  assign cs_load = cs_valid && ctrl.en && !ctrl.master;

  always_comb begin
    nxt      = time_q;
    adv_cyc  = 1'b0;
    sec_step = 1'b0;
    if (time_wr) begin
      nxt = ctime_t'(time_wdata);
    end else if (cs_load) begin
      nxt = ctime_t'(cs_time);
    end else if (ctrl.en) begin
      if (ctrl.src) begin
        if (src_strobe) begin
          nxt.off = '0;
          adv_cyc = 1'b1;
        end else if (tick && (time_q.off != OFF_MAX)) begin
          nxt.off = time_q.off + 1'b1;
        end
      end else if (tick) begin
        if (time_q.off == OFF_MAX) begin
          nxt.off = '0;
          adv_cyc = 1'b1;
        end else begin
          nxt.off = time_q.off + 1'b1;
        end
      end
      if (adv_cyc) begin
        if (time_q.cyc == CYC_MAX) begin
          nxt.cyc  = '0;
          sec_step = 1'b1;
          nxt.sec  = (time_q.sec == SEC_MAX) ? '0 : time_q.sec + 1'b1;
        end else begin
          nxt.cyc = time_q.cyc + 1'b1;
        end
      end
    end
  end

  assign roll = adv_cyc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) time_q <= '0;
    else        time_q <= nxt;
  end
endmodule

// File: rtl/ct_status.sv
module ct_status
  import ct_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  ctrl_t            ctrl,
  input  logic             roll,
  input  logic             sec_step,
  input  logic             cs_load,
  input  logic             cyc_done,
  input  logic [NFLAG-1:0] flag_clr,
  input  logic [NFLAG-1:0] mask,
  output logic             pending,
  output logic             lost,
  output logic [NFLAG-1:0] flags,
  output logic             irq
);
  logic             seen;
  logic             lost_evt;
  logic [NFLAG-1:0] set_vec;

  assign lost_evt = roll && !ctrl.master && seen && !cs_load;

  always_comb begin
    set_vec          = '0;
    set_vec[FB_SEC]  = sec_step;
    set_vec[FB_PEND] = roll;
    set_vec[FB_LOST] = lost_evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending <= 1'b0;
      seen    <= 1'b0;
      lost    <= 1'b0;
      flags   <= '0;
    end else begin
      if (roll)          pending <= 1'b1;
      else if (cyc_done) pending <= 1'b0;

      if (ctrl.master || cs_load) begin
        seen <= 1'b0;
        lost <= 1'b0;
      end else if (roll) begin
        if (seen) lost <= 1'b1;
        else      seen <= 1'b1;
      end

      flags <= (flags & ~flag_clr) | set_vec;
    end
  end

  assign irq = |(flags & mask);
endmodule

// File: rtl/cyc_timer.sv
module cyc_timer
  import ct_pkg::*;
#(
  parameter int OFF_WRAP = 3072,
  parameter int CYC_WRAP = 8000,
  parameter int SEC_WRAP = 128
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              src_strobe,
  input  logic              cs_valid,
  input  logic [TIME_W-1:0] cs_time,
  input  logic              cyc_done,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [TIME_W-1:0] reg_wdata,
  output logic [TIME_W-1:0] reg_rdata,
  output logic [TIME_W-1:0] cycle_time,
  output logic              cyc_pending,
  output logic              cyc_lost,
  output logic              irq
);
  ctrl_t            ctrl;
  ctime_t           time_q;
  logic [NFLAG-1:0] flags, mask, flag_clr;
  logic             time_wr, roll, sec_step, cs_load;

  ct_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_wr   (reg_wr),
    .reg_addr (reg_addr),
    .wdata_lo (reg_wdata[NFLAG-1:0]),
    .flags    (flags),
    .pending  (cyc_pending),
    .lost     (cyc_lost),
    .time_q   (time_q),
    .ctrl     (ctrl),
    .mask     (mask),
    .flag_clr (flag_clr),
    .time_wr  (time_wr),
    .rdata    (reg_rdata)
  );

  ct_counter #(
    .OFF_WRAP (OFF_WRAP),
    .CYC_WRAP (CYC_WRAP),
    .SEC_WRAP (SEC_WRAP)
  ) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctrl       (ctrl),
    .tick       (tick),
    .src_strobe (src_strobe),
    .cs_valid   (cs_valid),
    .cs_time    (cs_time),
    .time_wr    (time_wr),
    .time_wdata (reg_wdata),
    .time_q     (time_q),
    .roll       (roll),
    .sec_step   (sec_step),
    .cs_load    (cs_load)
  );

  ct_status u_stat (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctrl     (ctrl),
    .roll     (roll),
    .sec_step (sec_step),
    .cs_load  (cs_load),
    .cyc_done (cyc_done),
    .flag_clr (flag_clr),
    .mask     (mask),
    .pending  (cyc_pending),
    .lost     (cyc_lost),
    .flags    (flags),
    .irq      (irq)
  );

  assign cycle_time = time_q;
endmodule

// File: rtl/ct_checker.sv
module ct_checker
  import ct_pkg::*;
#(
  parameter int OFF_WRAP = 3072
)(
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [TIME_W-1:0] reg_wdata,
  input logic              cs_valid,
  input logic              src_strobe,
  input logic [TIME_W-1:0] cycle_time,
  input logic              cyc_pending,
  input logic              cyc_lost,
  input ctrl_t             ctrl,
  input logic [NFLAG-1:0]  flags
);
  logic wr_t, wr_f, cs_ok;
  assign wr_t  = reg_wr && (reg_addr == A_TIME);
  assign wr_f  = reg_wr && (reg_addr == A_FLAG);
  assign cs_ok = cs_valid && ctrl.en && !ctrl.master;

  AST_OFF_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_time[OFF_W-1:0] < OFF_W'(OFF_WRAP)); // R2

  AST_HOLD_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl.en && !wr_t) |=> $stable(cycle_time)); // R4

  AST_SRC_NO_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.en && ctrl.src && !src_strobe && !wr_t && !cs_ok) |=> $stable(cycle_time[TIME_W-1:OFF_W])); // R5

  AST_WRITE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_t |=> (cycle_time == $past(reg_wdata))); // R6

  AST_PEND_ON_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ((cycle_time[OFF_W-1:0] == '0) && ($past(cycle_time[OFF_W-1:0]) != '0) &&
     !$past(wr_t) && !$past(cs_ok)) |-> cyc_pending); // R8

  AST_LOST_MASTER: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ctrl.master) && ctrl.master) |-> !cyc_lost); // R9

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ((|flags) && !wr_f) |=> ((flags & $past(flags)) == $past(flags))); // R10
endmodule

bind cyc_timer ct_checker #(.OFF_WRAP(OFF_WRAP)) u_chk (.*);

// File: tb/sim_cyc_timer.sv
`timescale 1ns/1ps
module sim_cyc_timer;
  localparam int CLK_PERIOD = 10;
  localparam int OW = 6;
  localparam int CW = 5;
  localparam int SW = 4;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        tick = 0, src_strobe = 0, cs_valid = 0, cyc_done = 0, reg_wr = 0;
  logic [31:0] cs_time = 0, reg_wdata = 0;
  logic [7:0]  reg_addr = 0;
  logic [31:0] reg_rdata, cycle_time;
  logic        cyc_pending, cyc_lost, irq;

  int n_tests = 0, n_fail = 0;
  int e_off = 0, e_cyc = 0, e_sec = 0;
  bit e_pend = 0, e_lost = 0, e_seen = 0, e_en = 0, e_ms = 0, e_src = 0;
  bit [2:0] e_flags = 0, e_mask = 0;

  cyc_timer #(.OFF_WRAP(OW), .CYC_WRAP(CW), .SEC_WRAP(SW)) u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .src_strobe(src_strobe),
    .cs_valid(cs_valid), .cs_time(cs_time), .cyc_done(cyc_done),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .cycle_time(cycle_time),
    .cyc_pending(cyc_pending), .cyc_lost(cyc_lost), .irq(irq));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] pack_t(int s, int c, int o);
    return {7'(s), 13'(c), 12'(o)};
  endfunction

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic chk_all(string tag);
    chk(tag, "cycle_time", cycle_time, pack_t(e_sec, e_cyc, e_off));
    chk(tag, "pending", {31'b0, cyc_pending}, {31'b0, e_pend});
    chk(tag, "lost", {31'b0, cyc_lost}, {31'b0, e_lost});
    chk(tag, "irq", {31'b0, irq}, {31'b0, |(e_flags & e_mask)});
  endtask

  task automatic rd(string tag, logic [7:0] ad, logic [31:0] exp);
    reg_addr = ad;
    #1;
    chk(tag, "rdata", reg_rdata, exp);
  endtask

  task automatic step(bit tk, bit st, bit csv, logic [31:0] cst, bit dn,
                      bit wr, logic [7:0] ad, logic [31:0] wd);
    bit roll, sst, csl, lev;
    @(negedge clk);
    tick = tk; src_strobe = st; cs_valid = csv; cs_time = cst; cyc_done = dn;
    reg_wr = wr; reg_addr = ad; reg_wdata = wd;
    roll = 0; sst = 0; lev = 0;
    csl = csv && e_en && !e_ms;
    if (wr && ad == 8'h14) begin
      e_sec = int'(wd[31:25]); e_cyc = int'(wd[24:12]); e_off = int'(wd[11:0]);
    end else if (csl) begin
      e_sec = int'(cst[31:25]); e_cyc = int'(cst[24:12]); e_off = int'(cst[11:0]);
    end else if (e_en) begin
      if (e_src) begin
        if (st) begin e_off = 0; roll = 1; end
        else if (tk && e_off < OW-1) e_off++;
      end else if (tk) begin
        if (e_off == OW-1) begin e_off = 0; roll = 1; end
        else e_off++;
      end
      if (roll) begin
        if (e_cyc == CW-1) begin
          e_cyc = 0; sst = 1;
          e_sec = (e_sec == SW-1) ? 0 : e_sec + 1;
        end else e_cyc++;
      end
    end
    if (e_ms || csl) begin e_seen = 0; e_lost = 0; end
    else if (roll) begin
      if (e_seen) begin e_lost = 1; lev = 1; end
      else e_seen = 1;
    end
    if (roll) e_pend = 1;
    else if (dn) e_pend = 0;
    if (wr && ad == 8'h04) e_flags &= ~wd[2:0];
    e_flags |= {lev, roll, sst};
    if (wr && ad == 8'h00) {e_src, e_ms, e_en} = wd[2:0];
    if (wr && ad == 8'h08) e_mask = wd[2:0];
    @(posedge clk);
    #1;
    tick = 0; src_strobe = 0; cs_valid = 0; cyc_done = 0; reg_wr = 0;
  endtask

  task automatic wreg(logic [7:0] ad, logic [31:0] wd);
    step(0, 0, 0, 0, 0, 1, ad, wd);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog R1 actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk_all("R1 reset");
    rd("R1 ctrl", 8'h00, 0);
    rd("R1 flags", 8'h04, 0);
    rd("R1 mask", 8'h08, 0);
    rd("R1 timer", 8'h14, 0);
    @(negedge clk);
    rst_n = 1;

    // R2 R3: full sweep through seconds wrap, master, no source
    wreg(8'h00, 32'h3);
    wreg(8'h08, 32'h7);
    for (int i = 0; i < OW*CW*SW + 13; i++) begin
      step(1, 0, 0, 0, 0, 0, 0, 0);
      chk_all("R2 R3 sweep");
    end
    rd("R3 flags", 8'h04, {29'b0, e_flags});

    // R10: clear all flags, check irq against each mask value
    wreg(8'h04, 32'h7);
    chk_all("R10 clear");
    rd("R10 flags cleared", 8'h04, {29'b0, e_flags});
    wreg(8'h14, pack_t(SW-1, CW-1, OW-2));
    for (int m = 0; m < 8; m++) begin
      wreg(8'h08, 32'(m));
      step(1, 0, 0, 0, 0, 0, 0, 0);
      chk_all("R10 mask sweep");
      rd("R10 mask read", 8'h08, 32'(m));
    end
    // R10 set wins over clear in same clock
    wreg(8'h14, pack_t(0, 0, OW-1));
    step(1, 0, 0, 0, 0, 1, 8'h04, 32'h7);
    chk_all("R10 set wins");
    rd("R10 set wins flags", 8'h04, {29'b0, e_flags});

    // R8: sparse ticks with end-of-cycle pulses
    for (int i = 0; i < 60; i++) begin
      step((i % 3) == 0, 0, 0, 0, (i % 7) == 3, 0, 0, 0);
      chk_all("R8 sparse");
    end
    rd("R11 status", 8'h0C, {30'b0, e_lost, e_pend});
    // R8 set wins over cyc_done
    wreg(8'h14, pack_t(1, 2, OW-1));
    step(1, 0, 0, 0, 1, 0, 0, 0);
    chk_all("R8 set wins");

    // R4: disabled, ticks and cycle starts ignored
    wreg(8'h00, 32'h0);
    for (int i = 0; i < 8; i++) begin
      step(1, i[0], 1, pack_t(3, 4, 5), 0, 0, 0, 0);
      chk_all("R4 disabled");
    end

    // R6: write wins over tick, strobe and cycle start
    wreg(8'h00, 32'h1);
    step(1, 1, 1, pack_t(1, 1, 1), 0, 1, 8'h14, pack_t(2, 3, 4));
    chk_all("R6 write priority");
    rd("R6 timer read", 8'h14, pack_t(2, 3, 4));

    // R7: non-master load, master ignore
    step(1, 0, 1, pack_t(3, CW-1, OW-1), 0, 0, 0, 0);
    chk_all("R7 load");
    wreg(8'h00, 32'h3);
    step(1, 0, 1, pack_t(0, 1, 2), 0, 0, 0, 0);
    chk_all("R7 master ignore");

    // R5: source mode, saturation and strobe boundaries
    wreg(8'h00, 32'h7);
    rd("R11 ctrl", 8'h00, 32'h7);
    for (int i = 0; i < 70; i++) begin
      step(1, (i % 9) == 8, 0, 0, 0, 0, 0, 0);
      chk_all("R5 source");
    end

    // R9: non-master, lost after second boundary, cleared by cycle start
    wreg(8'h00, 32'h1);
    wreg(8'h04, 32'h7);
    for (int i = 0; i < 3*OW + 2; i++) begin
      step(1, 0, 0, 0, 0, 0, 0, 0);
      chk_all("R9 lost");
    end
    rd("R9 flags", 8'h04, {29'b0, e_flags});
    step(0, 0, 1, pack_t(1, 0, 0), 0, 0, 0, 0);
    chk_all("R9 cs clears");
    for (int i = 0; i < 2*OW + 1; i++) begin
      step(1, 0, 0, 0, 0, 0, 0, 0);
      chk_all("R9 relost");
    end
    wreg(8'h00, 32'h3);
    step(1, 0, 0, 0, 0, 0, 0, 0);
    chk_all("R9 master clears");

    rd("R11 unused", 8'h20, 0);
    rd("R11 mask", 8'h08, {29'b0, e_mask});

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule